// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the boundary-scan test access port of a processor core. It runs the standard sixteen-state TAP state machine, which is steered by TMS. Serial data on TDI goes into a 4-bit instruction register or into the data register that the current instruction selects. Serial data leaves on TDO, together with an enable that marks when TDO carries data. Two data registers exist: a 1-bit bypass register and a fixed 32-bit identification register.

The whole block runs on the core clock. TCK, TMS and TDI are external pins. Each one passes through a two-flop synchronizer, and the block finds the rising and falling edges of TCK inside the core clock domain. For this reason TCK must run at no more than half the core clock rate. In practice it should run a few times slower, so that each TCK phase spans the synchronizer latency.

A power-on reset (`rst_n`) and a separate active-low test reset (`trst_n`) both return the TAP to Test-Logic-Reset. The output `capture_dr` reports when the TAP sits in Capture-DR.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The TAP state advances once per detected rising TCK edge, following the standard sixteen-state graph with TMS as sampled at that edge. Between rising edges the state holds. TCK, TMS and TDI each pass through a two-flop synchronizer before use.
- R2: `tdo` and `tdo_en` change only in the core cycle after a detected falling TCK edge.
- R3: At each falling TCK edge, `tdo_en` becomes 1 if the state is Shift-DR or Shift-IR and becomes 0 in any other state. While `tdo_en` is 0, `tdo` is 0.
- R4: While `trst_n` is low, the TAP enters Test-Logic-Reset on the next core clock, and the instruction then selects the identification register.
- R5: While `rst_n` is low, the TAP is in Test-Logic-Reset and `tdo`, `tdo_en` and `capture_dr` are all 0. After reset the identification register is selected.
- R6: With `trst_n` held high, five rising TCK edges with TMS at 1 bring the TAP to Test-Logic-Reset from any state. This also restores the identification instruction.
- R7: `capture_dr` is 1 exactly while the TAP is in Capture-DR, and it is 0 in every other state, including Capture-IR.
- R8: The instruction register is 4 bits wide. On the rising edge that leaves Capture-IR, its shift stage loads 4'b0001. Data shifts least significant bit first, from TDI toward TDO. The new instruction takes effect on the rising edge that leaves Update-IR.
- R9: Code 4'b1111, and every code other than 4'b0010, selects the 1-bit bypass register. The bypass register captures 0 in Capture-DR, so TDO repeats TDI one TCK cycle later.
- R10: Code 4'b0010 selects the 32-bit identification register. Its value is the parameter `ID_VALUE` with bit 0 forced to 1. It is captured in Capture-DR and shifted out least significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tck | input | 1 | Test clock, sampled in the core clock domain |
| tms | input | 1 | Test mode select, sampled at rising TCK |
| tdi | input | 1 | Test data in, sampled at rising TCK |
| trst_n | input | 1 | Active-low test reset, forces Test-Logic-Reset |
| tdo | output | 1 | Test data out, updated after falling TCK |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| capture_dr | output | 1 | High while the TAP is in Capture-DR |

## Verification
A wrong TAP state shows up at the ports within one TCK cycle. It either moves `capture_dr` or changes `tdo_en` at the next falling edge, because these two outputs tie each port-visible state to one TMS pattern. A wrong instruction or a bad shift stage shows only when a register is scanned. The scan of the instruction register returns its 0001 capture pattern, the bypass scan shows a one-cycle delay, and the 32-bit identification scan gives back a known word. Errors inside the instruction register therefore surface at the end of the next scan, bit for bit.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SHIFT_DR = 4'd4,
        ST_EXIT1_DR = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EXIT2_DR = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SHIFT_IR = 4'd11,
        ST_EXIT1_IR = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EXIT2_IR = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_e;

    // Successor in the standard TAP graph for a given TMS value.
    function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
        tap_state_e nxt;
        case (cur)
            ST_RESET:    nxt = m ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   nxt = m ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = m ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: nxt = m ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = m ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: nxt = m ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = m ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   nxt = m ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   nxt = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = m ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: nxt = m ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = m ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: nxt = m ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = m ? ST_SEL_DR   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/jtag_tap_sync.sv
module jtag_tap_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    output logic tck_rise,
    output logic tck_fall,
    output logic tms_s,
    output logic tdi_s
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [TOP:0] tck;
        logic [TOP:0] tms;
        logic [TOP:0] tdi;
        logic         tck_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.tck      = {s_q.tck[TOP-1:0], tck};
        s_d.tms      = {s_q.tms[TOP-1:0], tms};
        s_d.tdi      = {s_q.tdi[TOP-1:0], tdi};
        s_d.tck_prev = s_q.tck[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tck_rise = s_q.tck[TOP] & ~s_q.tck_prev;
    assign tck_fall = ~s_q.tck[TOP] & s_q.tck_prev;
    assign tms_s    = s_q.tms[TOP];
    assign tdi_s    = s_q.tdi[TOP];
endmodule

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trst_n,
    input  logic       step,
    input  logic       tms_s,
    output tap_state_e state
);
    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!trst_n)   f_d.st = ST_RESET;
        else if (step) f_d.st = tap_next(f_q.st, tms_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_RESET};
        else        f_q <= f_d;
    end

    assign state = f_q.st;
endmodule

// File: rtl/jtag_tap_regs.sv
module jtag_tap_regs
    import jtag_tap_pkg::*;
#(
    parameter int                IR_W      = 4,
    parameter int                ID_W      = 32,
    parameter logic [ID_W-1:0]   ID_VALUE  = 32'h1B2C_3D4F,
    parameter logic [IR_W-1:0]   IDCODE_OP = 4'b0010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       fall,
    input  logic       tdi_s,
    input  tap_state_e state,
    output logic       tdo,
    output logic       tdo_en
);
    localparam logic [ID_W-1:0] ID_WORD  = ID_VALUE | ID_W'(1);
    localparam logic [IR_W-1:0] IR_CAPT  = IR_W'(1);

    typedef struct packed {
        logic [IR_W-1:0] ir_sh;
        logic [IR_W-1:0] ir;
        logic [ID_W-1:0] id_sh;
        logic            byp;
        logic            tdo;
        logic            tdo_en;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_id;

    assign sel_id = (r_q.ir == IDCODE_OP);

    always_comb begin
        r_d = r_q;
        if (state == ST_RESET) r_d.ir = IDCODE_OP;
        if (rise) begin
            case (state)
                ST_CAP_IR:   r_d.ir_sh = IR_CAPT;
                ST_SHIFT_IR: r_d.ir_sh = {tdi_s, r_q.ir_sh[IR_W-1:1]};
                ST_UPD_IR:   r_d.ir    = r_q.ir_sh;
                ST_CAP_DR: begin
                    if (sel_id) r_d.id_sh = ID_WORD;
                    else        r_d.byp   = 1'b0;
                end
                ST_SHIFT_DR: begin
                    if (sel_id) r_d.id_sh = {tdi_s, r_q.id_sh[ID_W-1:1]};
                    else        r_d.byp   = tdi_s;
                end
                default: ;
            endcase
        end
        if (fall) begin
            r_d.tdo_en = (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
            if (state == ST_SHIFT_IR)      r_d.tdo = r_q.ir_sh[0];
            else if (state == ST_SHIFT_DR) r_d.tdo = sel_id ? r_q.id_sh[0] : r_q.byp;
            else                           r_d.tdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.ir     <= IDCODE_OP;
            r_q.ir_sh  <= IR_CAPT;
        end else begin
            r_q <= r_d;
        end
    end

    assign tdo    = r_q.tdo;
    assign tdo_en = r_q.tdo_en;
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                IR_W        = 4,
    parameter int                ID_W        = 32,
    parameter logic [ID_W-1:0]   ID_VALUE    = 32'h1B2C_3D4F,
    parameter logic [IR_W-1:0]   IDCODE_OP   = 4'b0010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    input  logic trst_n,
    output logic tdo,
    output logic tdo_en,
    output logic capture_dr
);
    logic       tck_rise, tck_fall, tms_s, tdi_s;
    tap_state_e tap_state;

    jtag_tap_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
        .tck_rise(tck_rise), .tck_fall(tck_fall), .tms_s(tms_s), .tdi_s(tdi_s)
    );

    jtag_tap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trst_n(trst_n), .step(tck_rise),
        .tms_s(tms_s), .state(tap_state)
    );

    jtag_tap_regs #(
        .IR_W(IR_W), .ID_W(ID_W), .ID_VALUE(ID_VALUE), .IDCODE_OP(IDCODE_OP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rise(tck_rise), .fall(tck_fall),
        .tdi_s(tdi_s), .state(tap_state), .tdo(tdo), .tdo_en(tdo_en)
    );

    assign capture_dr = (tap_state == ST_CAP_DR);
endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       trst_n,
    input logic       tck_rise,
    input logic       tck_fall,
    input tap_state_e state,
    input logic       tdo,
    input logic       tdo_en,
    input logic       capture_dr
);
    // R4: test reset forces Test-Logic-Reset one clock later
    p_trst_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trst_n |=> state == ST_RESET);

    // R1: state only moves after a rising TCK edge or a test reset
    p_state_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> ($past(tck_rise) || !$past(trst_n)));

    // R1: a rising and a falling edge are never seen together
    p_edge_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(tck_rise && tck_fall));

    // R2: TDO and its enable change only after a falling edge
    p_tdo_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tdo) || !$stable(tdo_en)) |-> $past(tck_fall));

    // R3: TDO is quiet while not enabled
    p_tdo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tdo_en |-> !tdo);

    // R7: during Capture-DR the output enable is low
    p_cap_noen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr |-> !tdo_en);

    // R7: Capture-DR leaves only to Shift-DR or Exit1-DR
    p_cap_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_rise && trst_n && state == ST_CAP_DR) |=>
        (state == ST_SHIFT_DR || state == ST_EXIT1_DR));
endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .trst_n(trst_n), .tck_rise(tck_rise),
    .tck_fall(tck_fall), .state(tap_state), .tdo(tdo), .tdo_en(tdo_en),
    .capture_dr(capture_dr)
);

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;
    localparam int          HALF = 4;
    localparam logic [31:0] ID   = 32'h1B2C_3D4F;

    logic clk = 1'b0;
    logic rst_n = 1'b0, tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b1;
    logic tdo, tdo_en, capture_dr;
    int   checks = 0, errors = 0;

    always #5 clk = ~clk;

    jtag_tap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
        .trst_n(trst_n), .tdo(tdo), .tdo_en(tdo_en), .capture_dr(capture_dr)
    );

    // {tms, expected capture_dr, expected tdo_en}, walked from Test-Logic-Reset
    localparam logic [2:0] VEC [24] = '{
        3'b000, 3'b100, 3'b010, 3'b001, 3'b001, 3'b100, 3'b000, 3'b100,
        3'b001, 3'b100, 3'b100, 3'b000, 3'b100, 3'b100, 3'b000, 3'b001,
        3'b100, 3'b000, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b100
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tck_cycle(input logic m, input logic d);
        @(negedge clk); tms = m; tdi = d;
        repeat (HALF) @(negedge clk); tck = 1'b1;
        repeat (HALF) @(negedge clk); tck = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // From Run-Test/Idle to Run-Test/Idle through one data scan
    task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tck_cycle(i == n - 1, din[i]);
        end
        tck_cycle(1, 0); tck_cycle(0, 0);
    endtask

    task automatic ir_scan(input logic [3:0] din, output logic [3:0] dout);
        tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
        for (int i = 0; i < 4; i++) begin
            dout[i] = tdo;
            tck_cycle(i == 3, din[i]);
        end
        tck_cycle(1, 0); tck_cycle(0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d32;
        logic [3:0]  d4;
        repeat (5) @(negedge clk);
        check("R5 tdo_en in reset", {31'd0, tdo_en}, 0);
        check("R5 capture_dr in reset", {31'd0, capture_dr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 tdo after reset", {31'd0, tdo}, 0);

        // R1 R3 R7: state walk through both branches
        for (int i = 0; i < 24; i++) begin
            tck_cycle(VEC[i][2], 1'b0);
            check($sformatf("R7 capture_dr step %0d", i), {31'd0, capture_dr}, {31'd0, VEC[i][1]});
            check($sformatf("R3 tdo_en step %0d", i), {31'd0, tdo_en}, {31'd0, VEC[i][0]});
        end

        tck_cycle(0, 0);
        dr_scan(32, 32'h0, d32);
        check("R10 id after reset", d32, ID | 32'd1);

        ir_scan(4'hF, d4);
        check("R8 ir capture pattern", {28'd0, d4}, 32'h1);
        dr_scan(8, 32'hA5, d32);
        check("R9 bypass delay", d32, 32'h4A);

        ir_scan(4'h2, d4);
        check("R8 ir capture again", {28'd0, d4}, 32'h1);
        dr_scan(32, 32'hFFFF_0000, d32);
        check("R10 id via opcode", d32, ID | 32'd1);

        ir_scan(4'h5, d4);
        dr_scan(4, 32'hB, d32);
        check("R9 other code bypass", d32, 32'h6);

        // R6: five TMS ones from Shift-DR reach Test-Logic-Reset
        tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
        check("R3 enable in shift", {31'd0, tdo_en}, 1);
        for (int i = 0; i < 5; i++) tck_cycle(1, 0);
        check("R3 enable after exit", {31'd0, tdo_en}, 0);
        tck_cycle(0, 0);
        dr_scan(32, 32'h0, d32);
        check("R6 five ones restore id", d32, ID | 32'd1);

        // R4: test reset
        ir_scan(4'hF, d4);
        @(negedge clk); trst_n = 1'b0;
        repeat (4) @(negedge clk); trst_n = 1'b1;
        tck_cycle(0, 0);
        dr_scan(32, 32'h0, d32);
        check("R4 trst restores id", d32, ID | 32'd1);

        // R5: power-on reset mid-operation
        ir_scan(4'hF, d4);
        tck_cycle(1, 0); tck_cycle(0, 0);
        check("R7 capture before reset", {31'd0, capture_dr}, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R5 capture cleared", {31'd0, capture_dr}, 0);
        rst_n = 1'b1;
        tck_cycle(0, 0);
        dr_scan(32, 32'h0, d32);
        check("R5 reset restores id", d32, ID | 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule